// File: doc/BRIEF.md
# Nine-Bit Serial Receiver/Transmitter with Address Filtering

This block is a full-duplex asynchronous serial core built for multidrop networks where every character carries a ninth bit. The transmitter holds one pending byte in a holding register, moves it into a shift register when the line is free, and sends a start bit, eight data bits, the ninth bit and one or two stop bits. The ninth bit comes from a control bit that software sets before each send. The receiver oversamples the line sixteen times per bit. It samples each bit at its centre and places the character in a receive register together with its ninth bit and a framing-error flag.

When address filtering is enabled, the receiver discards every character whose ninth bit is 0. The first character whose ninth bit is 1 is accepted, and hardware then clears the filter enable, so the data characters that follow also arrive. Software can enable the filter again to skip traffic until the next address character. A diagnostic loopback routes the transmit shift output straight into the receiver and ignores the receive pin. A low-power reinitialisation strobe stops the transmitter, marks the holding register empty and clears the status flags. It leaves the control bits and the received data as they were.

Top module: `uart9_core`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, `rx_full` and `frame_err` are 0 and every control bit reads 0.
- R2: A `tx_wr` clears `tx_empty` for one cycle. The transmitter then sends, at 16 `baud_tick`s per bit: a 0 start bit, `tx_data` LSB first, the ninth bit taken from control bit 3, and a 1 stop bit. `txd` rests at 1 while idle.
- R3: The receiver samples each bit in its centre. After the stop bit it presents the eight data bits on `rx_data`, the ninth on `rx_bit9`, and sets `rx_full`. A `rx_rd` clears `rx_full` and `frame_err`.
- R4: A low level on the line that is gone by the centre of the start bit (8 ticks later) is ignored and delivers nothing.
- R5: A stop bit sampled as 0 sets `frame_err`, and the character is still delivered with `rx_full` set.
- R6: With control bit 0 (address filter) set, a character whose ninth bit is 0 is dropped. `rx_full`, `rx_data` and `rx_bit9` stay unchanged.
- R7: With the address filter set, a character whose ninth bit is 1 is delivered, and control bit 0 clears itself. A software write to the control register in the same cycle takes precedence.
- R8: With control bit 1 (loopback) set, the receiver takes its input from the transmit shift output and ignores `rxd`.
- R9: `rx_irq` is 1 exactly when `rx_full` is 1 and control bit 4 (receive interrupt enable) is 1.
- R10: A `lp_reinit` pulse makes `txd` 1 from the next cycle, abandons any frame in flight, sets `tx_empty` and clears `rx_full` and `frame_err`. It leaves the control bits, `rx_data` and `rx_bit9` unchanged, and the held byte is not sent.
- R11: A `tx_wr` in the same cycle as `lp_reinit` is stored but not sent. `tx_empty` ends at 1.
- R12: With control bit 2 (two stop bits) set, the transmitter keeps the line high for two bit periods after the ninth bit, so back-to-back frames start 12 bit periods apart instead of 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| lp_reinit | input | 1 | Low-power reinitialisation strobe |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 5 | Control: bit0 address filter, bit1 loopback, bit2 two stop bits, bit3 transmit ninth bit, bit4 receive interrupt enable |
| ctl_rdata | output | 5 | Control register readback |
| tx_wr | input | 1 | Loads `tx_data` into the holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register free |
| rx_rd | input | 1 | Acknowledges the received character |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted character |
| rx_full | output | 1 | Character waiting |
| frame_err | output | 1 | Stop bit of the last character was 0 |
| rx_irq | output | 1 | Receive interrupt |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The reinitialisation strobe and a transmit write can land in the same clock edge. The first would empty the holding register and the second would fill it. The bench drives `lp_reinit` and `tx_wr` high in one cycle. It then judges the outcome at the ports: `tx_empty` must read 1 and `txd` must stay high for longer than a full frame. A second collision is the address-filter self-clear against a control write. An assertion guards that case, and the bench checks the filter bit after each received address character.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    localparam int CTL_W = 5;

    // Control register; packed MSB first so addr_flt is bit 0
    typedef struct packed {
        logic rx_ie;
        logic tx_bit9;
        logic two_stop;
        logic loopback;
        logic addr_flt;
    } ctl_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_st_e;

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reinit,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit9,
    input  logic              two_stop,
    output logic              txd,
    output logic              empty
);
    localparam int CNT_W = $clog2(OVS);
    localparam int SHF_W = DATA_W + 4;          // start, data, ninth, two stops
    localparam int LEN_W = $clog2(SHF_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              busy;
        logic [SHF_W-1:0]  shf;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  left;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && tick) begin
            if (st_q.cnt == CNT_W'(OVS - 1)) begin
                st_d.cnt  = '0;
                st_d.shf  = {1'b1, st_q.shf[SHF_W-1:1]};
                st_d.left = st_q.left - LEN_W'(1);
                if (st_q.left == LEN_W'(1)) begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (!st_q.busy && !st_q.empty) begin
            st_d.shf   = {2'b11, bit9, st_q.hold, 1'b0};
            st_d.left  = two_stop ? LEN_W'(SHF_W) : LEN_W'(SHF_W - 1);
            st_d.cnt   = '0;
            st_d.busy  = 1'b1;
            st_d.empty = 1'b1;
        end
        if (wr) begin
            st_d.hold  = wdata;
            st_d.empty = 1'b0;
        end
        if (reinit) begin
            st_d.shf   = '1;
            st_d.busy  = 1'b0;
            st_d.empty = 1'b1;
            st_d.cnt   = '0;
            st_d.left  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shf   <= '1;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd   = st_q.shf[0];
    assign empty = st_q.empty;

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> txd); // R2
    AST_TX_REINIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (txd && empty && !st_q.busy)); // R10

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic              dv,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              stop_ok
);
    import uart9_pkg::*;

    localparam int CNT_W   = $clog2(OVS);
    localparam int FRAME_W = DATA_W + 1;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int MID     = OVS / 2 - 1;

    typedef struct packed {
        rx_st_e             st;
        logic               armed;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] shf;
        logic               dv;
        logic               stop;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        case (st_q.st)
            RX_IDLE: begin
                if (!st_q.armed) begin
                    if (line) st_d.armed = 1'b1;
                end else if (tick && !line) begin
                    st_d.st  = RX_START;
                    st_d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.cnt == CNT_W'(MID)) begin
                        st_d.cnt = '0;
                        st_d.idx = '0;
                        st_d.st  = line ? RX_IDLE : RX_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (st_q.cnt == CNT_W'(OVS - 1)) begin
                        st_d.cnt = '0;
                        st_d.shf = {line, st_q.shf[FRAME_W-1:1]};
                        if (st_q.idx == IDX_W'(FRAME_W - 1)) begin
                            st_d.st = RX_STOP;
                        end else begin
                            st_d.idx = st_q.idx + IDX_W'(1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (st_q.cnt == CNT_W'(OVS - 1)) begin
                        st_d.cnt   = '0;
                        st_d.dv    = 1'b1;
                        st_d.stop  = line;
                        st_d.armed = line;
                        st_d.st    = RX_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: st_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dv      = st_q.dv;
    assign data    = st_q.shf[DATA_W-1:0];
    assign bit9    = st_q.shf[FRAME_W-1];
    assign stop_ok = st_q.stop;

    AST_START_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == RX_START && tick && st_q.cnt == CNT_W'(MID) && line)
        |=> (st_q.st == RX_IDLE && !dv)); // R4
    AST_DV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dv |=> !dv); // R3

endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       baud_tick,
    input  logic                       lp_reinit,
    input  logic                       ctl_wr,
    input  logic [uart9_pkg::CTL_W-1:0] ctl_wdata,
    output logic [uart9_pkg::CTL_W-1:0] ctl_rdata,
    input  logic                       tx_wr,
    input  logic [DATA_W-1:0]          tx_data,
    output logic                       tx_empty,
    input  logic                       rx_rd,
    output logic [DATA_W-1:0]          rx_data,
    output logic                       rx_bit9,
    output logic                       rx_full,
    output logic                       frame_err,
    output logic                       rx_irq,
    input  logic                       rxd,
    output logic                       txd
);
    import uart9_pkg::*;

    typedef struct packed {
        ctl_t                   ctl;
        logic [DATA_W-1:0]      rdat;
        logic                   rb9;
        logic                   full;
        logic                   ferr;
        logic [SYNC_STAGES-1:0] sync;
    } core_state_t;

    core_state_t st_d, st_q;

    logic              txd_int;
    logic              rx_line;
    logic              rx_dv;
    logic [DATA_W-1:0] rx_word;
    logic              rx_b9;
    logic              rx_stop;
    logic              drop_char;

    assign rx_line   = st_q.ctl.loopback ? txd_int : st_q.sync[SYNC_STAGES-1];
    assign drop_char = st_q.ctl.addr_flt && !rx_b9;

    uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .reinit   (lp_reinit),
        .wr       (tx_wr),
        .wdata    (tx_data),
        .bit9     (st_q.ctl.tx_bit9),
        .two_stop (st_q.ctl.two_stop),
        .txd      (txd_int),
        .empty    (tx_empty)
    );

    uart9_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .line    (rx_line),
        .dv      (rx_dv),
        .data    (rx_word),
        .bit9    (rx_b9),
        .stop_ok (rx_stop)
    );

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], rxd};
        end else begin
            st_d.sync = SYNC_STAGES'(rxd);
        end
        if (rx_rd) begin
            st_d.full = 1'b0;
            st_d.ferr = 1'b0;
        end
        if (rx_dv && !drop_char) begin
            st_d.rdat         = rx_word;
            st_d.rb9          = rx_b9;
            st_d.full         = 1'b1;
            st_d.ferr         = !rx_stop;
            st_d.ctl.addr_flt = 1'b0;
        end
        if (ctl_wr) begin
            st_d.ctl = ctl_t'(ctl_wdata);
        end
        if (lp_reinit) begin
            st_d.full = 1'b0;
            st_d.ferr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_rdata = st_q.ctl;
    assign rx_data   = st_q.rdat;
    assign rx_bit9   = st_q.rb9;
    assign rx_full   = st_q.full;
    assign frame_err = st_q.ferr;
    assign rx_irq    = st_q.full && st_q.ctl.rx_ie;
    assign txd       = txd_int;

    AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && drop_char && !rx_rd && !lp_reinit)
        |=> ($stable(rx_full) && $stable(rx_data) && $stable(rx_bit9))); // R6
    AST_ADDR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && ctl_rdata[0] && rx_b9 && !ctl_wr && !lp_reinit)
        |=> (!ctl_rdata[0] && rx_full)); // R7
    AST_FERR_KEEPS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && !drop_char && !rx_stop && !lp_reinit)
        |=> (frame_err && rx_full)); // R5
    AST_REINIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        lp_reinit |=> (tx_empty && !rx_full && !frame_err && txd)); // R10
    AST_REINIT_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_reinit && !ctl_wr && !rx_dv) |=> $stable(ctl_rdata)); // R10

endmodule

// File: tb/uart9_core_bench.sv
module uart9_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       lp_reinit = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_empty;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_full;
    logic       frame_err;
    logic       rx_irq;
    logic       rxd = 1'b1;
    logic       txd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    logic [1:0] tcnt = '0;
    always @(negedge clk) begin
        tcnt      <= tcnt + 2'd1;
        baud_tick <= (tcnt == 2'd3);
    end

    uart9_core u_uart9_core (
        .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick), .lp_reinit (lp_reinit),
        .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .ctl_rdata (ctl_rdata),
        .tx_wr (tx_wr), .tx_data (tx_data), .tx_empty (tx_empty),
        .rx_rd (rx_rd), .rx_data (rx_data), .rx_bit9 (rx_bit9), .rx_full (rx_full),
        .frame_err (frame_err), .rx_irq (rx_irq), .rxd (rxd), .txd (txd)
    );

    localparam int BITC = 64;   // clocks per bit: 16 ticks of 4 clocks
    localparam int NV = 8;
    // {write ctl, filter value, stop level, ninth bit, byte}
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 1'b0, 8'hA5},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h3C},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h11},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h22},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h80},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h5A},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'hC3}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [4:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic read_ack();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp);
        rxd = 1'b0; repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; repeat (BITC) @(negedge clk);
        end
        rxd = b9;  repeat (BITC) @(negedge clk);
        rxd = stp; repeat (BITC) @(negedge clk);
        rxd = 1'b1; repeat (BITC) @(negedge clk);
    endtask

    task automatic wait_txd_low(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!txd) begin seen = 1'b1; break; end
        end
    endtask

    task automatic grab_frame(output logic [8:0] bits, output logic st0, output logic sp);
        bit seen;
        wait_txd_low(seen);
        wait_ticks(8);
        st0 = txd;
        for (int i = 0; i < 9; i++) begin
            wait_ticks(16);
            bits[i] = txd;
        end
        wait_ticks(16);
        sp = txd;
    endtask

    task automatic frame_gap(input logic [4:0] ctlv, output int gap);
        bit seen;
        ctl_write(ctlv);
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'hFF;
        @(negedge clk); tx_wr = 1'b0;
        @(negedge clk); tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        wait_txd_low(seen);
        gap = 0;
        while (!txd) begin @(negedge clk); gap++; end
        while (txd && gap < 2000) begin @(negedge clk); gap++; end
        repeat (14 * BITC) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        logic [8:0] bits;
        logic       st0, sp, m_flt, acc;
        logic [7:0] e_data;
        logic       e_b9, e_ferr;
        logic [4:0] ctl_snap;
        logic [7:0] dat_snap;
        int         gap1, gap2;
        bit         seen, quiet;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(!rx_full && !frame_err, "R1 flags", {rx_full, frame_err}, 0);
        chk(ctl_rdata == 5'd0, "R1 ctl", ctl_rdata, 0);
        repeat (8) @(negedge clk);

        // Receive vector table: R3 R5 R6 R7 R9
        m_flt = 1'b0; e_data = rx_data; e_b9 = rx_bit9;
        for (int i = 0; i < NV; i++) begin
            read_ack();
            if (VEC[i][11]) begin
                ctl_write({1'b1, 3'b000, VEC[i][10]});
                m_flt = VEC[i][10];
            end
            send_frame(VEC[i][7:0], VEC[i][8], VEC[i][9]);
            repeat (8) @(negedge clk);
            acc = !(m_flt && !VEC[i][8]);
            if (acc) begin
                e_data = VEC[i][7:0]; e_b9 = VEC[i][8]; e_ferr = !VEC[i][9]; m_flt = 1'b0;
            end else begin
                e_ferr = 1'b0;
            end
            chk(rx_full == acc, "R3/R6 rx_full", rx_full, acc);
            chk(rx_data == e_data, "R3/R6 rx_data", rx_data, e_data);
            chk(rx_bit9 == e_b9, "R3 rx_bit9", rx_bit9, e_b9);
            chk(frame_err == e_ferr, "R5 frame_err", frame_err, e_ferr);
            chk(ctl_rdata[0] == m_flt, "R7 filter bit", ctl_rdata[0], m_flt);
            chk(rx_irq == acc, "R9 rx_irq", rx_irq, acc);
        end

        // R9 interrupt masked while rx_full set
        ctl_write(5'b00000);
        chk(rx_full && !rx_irq, "R9 masked irq", {rx_full, rx_irq}, 2);

        // R4 short start glitch
        read_ack();
        rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
        repeat (14 * BITC) @(negedge clk);
        chk(!rx_full, "R4 glitch ignored", rx_full, 0);

        // R2 transmit frame with ninth bit 1
        ctl_write(5'b01000);
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h4B;
        @(negedge clk); tx_wr = 1'b0;
        chk(!tx_empty, "R2 empty cleared", tx_empty, 0);
        @(negedge clk);
        chk(tx_empty, "R2 moved to shifter", tx_empty, 1);
        grab_frame(bits, st0, sp);
        chk(st0 == 1'b0, "R2 start bit", st0, 0);
        chk(bits == 9'h14B, "R2 frame bits", bits, 9'h14B);
        chk(sp == 1'b1, "R2 stop bit", sp, 1);
        repeat (2 * BITC) @(negedge clk);

        // R12 one versus two stop bits
        frame_gap(5'b01000, gap1);
        frame_gap(5'b01100, gap2);
        chk(gap1 >= 11 * BITC - 8 && gap1 <= 11 * BITC + 8, "R12 one stop spacing", gap1, 11 * BITC);
        chk(gap2 >= 12 * BITC - 8 && gap2 <= 12 * BITC + 8, "R12 two stop spacing", gap2, 12 * BITC);

        // R8 loopback with rxd held low
        read_ack();
        rxd = 1'b0;
        ctl_write(5'b11010);
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h96;
        @(negedge clk); tx_wr = 1'b0;
        repeat (14 * BITC) @(negedge clk);
        chk(rx_full, "R8 loopback delivered", rx_full, 1);
        chk(rx_data == 8'h96 && rx_bit9, "R8 loopback data", {rx_bit9, rx_data}, 9'h196);
        chk(!frame_err, "R8 loopback stop", frame_err, 0);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        ctl_write(5'b10000);
        repeat (4 * BITC) @(negedge clk);

        // R10 reinit in the middle of a frame, rx_full set beforehand
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h00;
        @(negedge clk); tx_wr = 1'b0;
        wait_txd_low(seen);
        wait_ticks(40);
        ctl_snap = ctl_rdata; dat_snap = rx_data;
        chk(rx_full && !txd, "R10 precondition", {rx_full, txd}, 2);
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h0F;
        @(negedge clk); tx_wr = 1'b0; lp_reinit = 1'b1;
        @(negedge clk); lp_reinit = 1'b0;
        chk(txd == 1'b1, "R10 txd high", txd, 1);
        chk(tx_empty, "R10 tx_empty", tx_empty, 1);
        chk(!rx_full && !frame_err, "R10 flags cleared", {rx_full, frame_err}, 0);
        chk(ctl_rdata == ctl_snap, "R10 ctl kept", ctl_rdata, ctl_snap);
        chk(rx_data == dat_snap, "R10 rx_data kept", rx_data, dat_snap);
        quiet = 1'b1;
        for (int i = 0; i < 14 * BITC; i++) begin
            @(negedge clk);
            if (!txd) quiet = 1'b0;
        end
        chk(quiet, "R10 held byte not sent", quiet, 1);

        // R11 reinit colliding with a write
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'h00; lp_reinit = 1'b1;
        @(negedge clk); tx_wr = 1'b0; lp_reinit = 1'b0;
        chk(tx_empty, "R11 tx_empty", tx_empty, 1);
        quiet = 1'b1;
        for (int i = 0; i < 14 * BITC; i++) begin
            @(negedge clk);
            if (!txd) quiet = 1'b0;
        end
        chk(quiet, "R11 nothing sent", quiet, 1);

        finish_run();
    end

endmodule